// File: doc/BRIEF.md
# Auto-Incrementing Indirect RAM Port

This block gives a host indirect access to a 256-byte memory through two locations of a byte-wide register window. The memory has no direct mapping. The host first writes a start address into the pointer register. Each access to the data-port register then moves one byte at the pointer and steps the pointer by one. A block of any length can therefore be transferred by writing the start address once and then accessing the data port repeatedly.

The bus has one register offset input, separate read and write strobes, a write-data byte and a read-data byte. Read data comes from a registered path. It is valid in the cycle after the read strobe and holds until the next accepted read. Offsets other than the two used here belong to other logic: writes to them are ignored, and reads of them return zero.

Top module: `ram_window_port`

## Requirements
- R1: After reset the pointer is 0x00 and `reg_rdata` is 0x00.
- R2: A write to offset 0x10 loads the pointer with `reg_wdata`. A read of offset 0x10 returns the current pointer on `reg_rdata` in the following cycle.
- R3: A write to offset 0x13 stores `reg_wdata` at the pointer address and advances the pointer by one.
- R4: A read of offset 0x13 returns the byte at the pointer address on `reg_rdata` in the following cycle and advances the pointer by one.
- R5: The pointer wraps from 0xFF to 0x00 when it advances, so a transfer crosses the top of memory seamlessly.
- R6: A write to offset 0x10 changes no memory contents.
- R7: A read of offset 0x10 leaves the pointer unchanged.
- R8: At any offset other than 0x10 and 0x13, a write changes neither memory nor pointer, and a read returns 0x00.
- R9: When both strobes are high in the same cycle, only the write is performed. `reg_rdata` keeps its previous value and the pointer advances at most once.
- R10: `reg_rdata` keeps its value in every cycle that follows a cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 5 | Register-window offset |
| reg_wr | input | 1 | Write strobe, one access per cycle high |
| reg_rd | input | 1 | Read strobe, one access per cycle high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after a read |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, 8-bit data and a 5-bit offset. With these values, a walk over all 256 locations fits in a short run. The same parameters reach the 0xFF-to-0x00 wrap both in the middle of a transfer and in a full-memory sweep. They also place the pointer and data offsets between decoded-away neighbours such as 0x11 and 0x12, which is where the R8 ignore checks are made.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  // Kind of register-window location touched by one access
  typedef enum logic [1:0] {
    RWP_NONE = 2'd0,
    RWP_PTR  = 2'd1,
    RWP_DATA = 2'd2
  } rwp_kind_e;
endpackage

// File: rtl/rwp_rst_sync.sv
module rwp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rwp_decode.sv
module rwp_decode
  import rwp_pkg::*;
#(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned PTR_OFS  = 16,
  parameter int unsigned DATA_OFS = 19
) (
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output rwp_kind_e         kind,
  output logic              ptr_load,
  output logic              mem_we,
  output logic              mem_re,
  output logic              rd_accept,
  output logic              ptr_step
);
  localparam logic [REG_AW-1:0] PtrAddr  = REG_AW'(PTR_OFS);
  localparam logic [REG_AW-1:0] DataAddr = REG_AW'(DATA_OFS);

  logic rd_only;

  always_comb begin
    if (reg_addr == PtrAddr)       kind = RWP_PTR;
    else if (reg_addr == DataAddr) kind = RWP_DATA;
    else                           kind = RWP_NONE;
  end

  // A write strobe wins over a read strobe in the same cycle
  assign rd_only   = reg_rd && !reg_wr;
  assign ptr_load  = reg_wr && (kind == RWP_PTR);
  assign mem_we    = reg_wr && (kind == RWP_DATA);
  assign mem_re    = rd_only && (kind == RWP_DATA);
  assign rd_accept = rd_only;
  assign ptr_step  = mem_we || mem_re;
endmodule

// File: rtl/rwp_pointer.sv
module rwp_pointer #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_en = load || step;
    ptr_d  = ptr_q;
    if (load)      ptr_d = load_val;
    else if (step) ptr_d = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/rwp_ram.sv
module rwp_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];
  logic [DATA_W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q_r <= mem[addr];
  end

  assign rdata = q_r;
endmodule

// File: rtl/rwp_readback.sv
module rwp_readback
  import rwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_accept,
  input  rwp_kind_e         kind,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] rdata
);
  rwp_kind_e         src_q;
  rwp_kind_e         src_d;
  logic [DATA_W-1:0] ptr_cap_q;
  logic [DATA_W-1:0] ptr_cap_d;
  logic [DATA_W-1:0] ptr_ext;

  generate
    if (ADDR_W < DATA_W) begin : g_pad
      assign ptr_ext = {{(DATA_W-ADDR_W){1'b0}}, ptr};
    end else begin : g_trunc
      assign ptr_ext = ptr[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    src_d     = rd_accept ? kind : src_q;
    ptr_cap_d = (rd_accept && kind == RWP_PTR) ? ptr_ext : ptr_cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= RWP_NONE;
      ptr_cap_q <= '0;
    end else if (rd_accept) begin
      src_q     <= src_d;
      ptr_cap_q <= ptr_cap_d;
    end
  end

  always_comb begin
    case (src_q)
      RWP_DATA: rdata = ram_q;
      RWP_PTR:  rdata = ptr_cap_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/ram_window_port.sv
module ram_window_port
  import rwp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned PTR_OFS  = 16,
  parameter int unsigned DATA_OFS = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic              rst_n_s;
  rwp_kind_e         kind;
  logic              ptr_load;
  logic              mem_we;
  logic              mem_re;
  logic              rd_accept;
  logic              ptr_step;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] load_val;
  logic [DATA_W-1:0] ram_q;

  generate
    if (ADDR_W <= DATA_W) begin : g_load_slice
      assign load_val = reg_wdata[ADDR_W-1:0];
    end else begin : g_load_pad
      assign load_val = {{(ADDR_W-DATA_W){1'b0}}, reg_wdata};
    end
  endgenerate

  rwp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rwp_decode #(
    .REG_AW   (REG_AW),
    .PTR_OFS  (PTR_OFS),
    .DATA_OFS (DATA_OFS)
  ) u_dec (
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .kind      (kind),
    .ptr_load  (ptr_load),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .rd_accept (rd_accept),
    .ptr_step  (ptr_step)
  );

  rwp_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (ptr_load),
    .load_val (load_val),
    .step     (ptr_step),
    .ptr      (ptr)
  );

  rwp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (ptr),
    .wdata (reg_wdata),
    .rdata (ram_q)
  );

  rwp_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_accept (rd_accept),
    .kind      (kind),
    .ptr       (ptr),
    .ram_q     (ram_q),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/ram_window_port_chk.sv
module ram_window_port_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned PTR_OFS  = 16,
  parameter int unsigned DATA_OFS = 19
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [ADDR_W-1:0] ptr
);
  localparam logic [REG_AW-1:0] PA = REG_AW'(PTR_OFS);
  localparam logic [REG_AW-1:0] DA = REG_AW'(DATA_OFS);

  logic hit_ptr, hit_data;
  assign hit_ptr  = (reg_addr == PA);
  assign hit_data = (reg_addr == DA);

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && hit_ptr) |=> ptr == ADDR_W'($past(reg_wdata))); // R2

  AST_PTR_READBACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rd && !reg_wr && hit_ptr) |=> reg_rdata == DATA_W'($past(ptr))); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((reg_wr || reg_rd) && hit_data) |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R5

  AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!(reg_wr && hit_ptr) && !((reg_wr || reg_rd) && hit_data)) |=> $stable(ptr)); // R7

  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rd && !reg_wr && !hit_ptr && !hit_data) |=> reg_rdata == '0); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!reg_rd || reg_wr) |=> $stable(reg_rdata)); // R10
endmodule

bind ram_window_port ram_window_port_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .REG_AW   (REG_AW),
  .PTR_OFS  (PTR_OFS),
  .DATA_OFS (DATA_OFS)
) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .ptr       (ptr)
);

// File: tb/sim_ram_window_port.sv
`timescale 1ns/1ps
module sim_ram_window_port;
  localparam logic [4:0] OFS_PTR  = 5'h10;
  localparam logic [4:0] OFS_DATA = 5'h13;

  logic       clk;
  logic       rst_n;
  logic [4:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ram_window_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1; reg_wr = 1'b0;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata after reset", reg_rdata, 8'h00);
    bus_rd(OFS_PTR, v);
    check("R1 pointer after reset", v, 8'h00);
  endtask

  task automatic t_ptr_load();
    logic [7:0] v;
    bus_wr(OFS_PTR, 8'h35);
    bus_rd(OFS_PTR, v);
    check("R2 pointer load", v, 8'h35);
    bus_rd(OFS_PTR, v);
    check("R7 pointer read no advance", v, 8'h35);
  endtask

  task automatic t_block();
    logic [7:0] v;
    bus_wr(OFS_PTR, 8'h40);
    for (int i = 0; i < 8; i++) bus_wr(OFS_DATA, 8'hA0 + 8'(i));
    bus_rd(OFS_PTR, v);
    check("R3 pointer after block write", v, 8'h48);
    bus_wr(OFS_PTR, 8'h40);
    for (int i = 0; i < 8; i++) begin
      bus_rd(OFS_DATA, v);
      check("R4 block read byte", v, 8'hA0 + 8'(i));
    end
    bus_rd(OFS_PTR, v);
    check("R4 pointer after block read", v, 8'h48);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    bus_wr(OFS_PTR, 8'hFE);
    bus_wr(OFS_DATA, 8'h11);
    bus_wr(OFS_DATA, 8'h22);
    bus_wr(OFS_DATA, 8'h33);
    bus_rd(OFS_PTR, v);
    check("R5 pointer after wrap", v, 8'h01);
    bus_wr(OFS_PTR, 8'hFF);
    bus_rd(OFS_DATA, v);
    check("R5 byte at 0xFF", v, 8'h22);
    bus_rd(OFS_DATA, v);
    check("R5 byte at 0x00 after wrap", v, 8'h33);
  endtask

  task automatic t_ptr_no_mem();
    logic [7:0] v;
    bus_wr(OFS_PTR, 8'h42);
    bus_wr(OFS_PTR, 8'h42);
    bus_wr(OFS_PTR, 8'h42);
    bus_rd(OFS_DATA, v);
    check("R6 memory untouched by pointer writes", v, 8'hA2);
  endtask

  task automatic t_other();
    logic [7:0] v;
    bus_wr(OFS_PTR, 8'h44);
    bus_wr(5'h11, 8'h99);
    bus_wr(5'h12, 8'h98);
    bus_wr(5'h00, 8'h97);
    bus_rd(OFS_PTR, v);
    check("R8 pointer after foreign writes", v, 8'h44);
    bus_rd(5'h12, v);
    check("R8 foreign read is zero", v, 8'h00);
    bus_rd(5'h1F, v);
    check("R8 foreign read high offset is zero", v, 8'h00);
    bus_rd(OFS_DATA, v);
    check("R8 memory after foreign writes", v, 8'hA4);
  endtask

  task automatic t_both();
    logic [7:0] v;
    bus_wr(OFS_PTR, 8'h60);
    bus_rd(OFS_PTR, v);
    @(negedge clk);
    reg_addr = OFS_DATA; reg_wdata = 8'h77; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    check("R9 rdata held on dual strobe", reg_rdata, 8'h60);
    bus_rd(OFS_PTR, v);
    check("R9 pointer advanced once", v, 8'h61);
    bus_wr(OFS_PTR, 8'h60);
    bus_rd(OFS_DATA, v);
    check("R9 write performed", v, 8'h77);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    bus_wr(OFS_PTR, 8'h41);
    bus_rd(OFS_DATA, v);
    check("R10 read before hold", v, 8'hA1);
    bus_wr(OFS_DATA, 8'h5A);
    bus_wr(OFS_PTR, 8'h10);
    repeat (4) @(negedge clk);
    check("R10 rdata held without reads", reg_rdata, 8'hA1);
  endtask

  task automatic t_sweep();
    logic [7:0] v;
    int bad = 0;
    bus_wr(OFS_PTR, 8'h00);
    for (int i = 0; i < 256; i++) bus_wr(OFS_DATA, 8'(i * 7 + 3));
    bus_wr(OFS_PTR, 8'h00);
    for (int i = 0; i < 256; i++) begin
      bus_rd(OFS_DATA, v);
      if (v !== 8'(i * 7 + 3)) begin
        bad++;
        check("R3 R4 sweep byte", v, 8'(i * 7 + 3));
      end
    end
    check("R3 R4 sweep mismatches", 8'(bad), 8'h00);
    bus_rd(OFS_PTR, v);
    check("R5 pointer after full sweep", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ptr_load();
    t_block();
    t_wrap();
    t_ptr_no_mem();
    t_other();
    t_both();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule